// File: doc/BRIEF.md
# Multi-Mode Effective Address Generator

This unit turns an addressing-mode code plus the register values a processor has already read (a base register, an index register and the program counter) and an immediate field into the final operand or branch-target address. It covers the usual register-based modes, an absolute mode, two auto-modifying modes that also return an updated base value for the register file, two forms of PC-relative target, and a memory-indirect mode. In the memory-indirect mode the unit issues one read and uses the returned word as the address.

A request is a one-cycle `start` pulse with all operands valid in that cycle. Every mode except memory-indirect answers one cycle later with `done`, the address on `ea` and, for the auto-modify modes, `wb_en` with the new base on `wb_data`. For memory-indirect the unit raises `mem_req` with the read address and waits for `mem_valid`. The cycle after that, `done` rises and `ea` carries the returned word. The register file, the operation on the operand and instruction decode are outside this block.

Top module: `eff_addr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `wb_en`, `mem_req` and `busy` are low.
- R2: Mode 0 (displacement) gives `base + sign-extend(imm[15:0])`. Mode 1 (register indirect) gives `base`.
- R3: Mode 2 (indexed) gives `base + index`. Mode 3 (absolute) gives `imm` unchanged.
- R4: Mode 5 (post-increment) gives `ea = base` and `wb_data = base + (1 << size)`, where size 0..3 selects 1, 2, 4 or 8 bytes.
- R5: Mode 6 (pre-decrement) gives `ea = wb_data = base - (1 << size)`. All address arithmetic wraps modulo 2^32.
- R6: Mode 7 (PC-relative branch) gives `pc + sign-extend(imm[15:0])`.
- R7: Mode 8 (PC-relative jump) gives `{pc[31:26], imm[25:0]}`.
- R8: For every mode other than 4, `done` is high exactly in the cycle after `start` and low in the cycle after that when no new start is given.
- R9: Mode 4 (memory indirect) raises `mem_req` in the cycle after `start`, with `mem_addr = base`. Both are held until `mem_valid` is seen. In the next cycle `done` is high, `ea` equals the `mem_data` that came with `mem_valid`, and `mem_req` is low.
- R10: `wb_en` is high only together with `done` for modes 5 and 6. It is never high for any other mode, memory indirect included.
- R11: A `start` while `busy` is high is ignored, and so is a `mem_valid` while no fetch is outstanding. Neither produces `done`, and neither changes a pending fetch.
- R12: Mode codes 9 to 15 complete like R8 with `ea = 0` and `wb_en` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, operands valid this cycle |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Access size, step is 1 << size bytes |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| pc | input | 32 | Program counter |
| imm | input | 32 | Immediate, displacement or jump field |
| mem_req | output | 1 | Indirect read request |
| mem_addr | output | 32 | Indirect read address |
| mem_valid | input | 1 | Read data valid |
| mem_data | input | 32 | Read data |
| busy | output | 1 | Indirect fetch outstanding |
| done | output | 1 | Result valid strobe |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base write-back enable |
| wb_data | output | 32 | Updated base value |

## Verification
The bench checks that pre-decrement wraps from a base of zero to all ones. A unit that updated the base after using it, or that took the step from the wrong size, would return an address one step off. Negative displacements and branch offsets are driven to catch zero-extension, which would add about 64 KiB instead of subtracting. Memory-indirect requests are answered after varying delays and with a second start in the middle, so a unit that dropped the request early, restarted on the stray start or raised the write-back enable would produce the wrong `ea` or a spurious `wb_en`. Stray `mem_valid` pulses in idle and undefined mode codes are also driven; a unit that accepted them would emit a spurious `done` or a nonzero address.

// File: rtl/eau_pkg.sv
package eau_pkg;

  typedef enum logic [3:0] {
    M_DISP    = 4'd0,
    M_REGIND  = 4'd1,
    M_INDEX   = 4'd2,
    M_ABS     = 4'd3,
    M_MEMIND  = 4'd4,
    M_POSTINC = 4'd5,
    M_PREDEC  = 4'd6,
    M_PCREL   = 4'd7,
    M_PCJMP   = 4'd8
  } mode_e;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_FETCH = 1'b1
  } state_e;

endpackage

// File: rtl/eau_calc.sv
module eau_calc #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int JW = 26
) (
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] imm,
  output logic [AW-1:0] addr,
  output logic [AW-1:0] wb_val,
  output logic          wb_sel,
  output logic          is_indirect
);
  import eau_pkg::*;

  localparam int EXT = AW - DW;
  localparam int HI  = AW - JW;

  function automatic logic [AW-1:0] sext_disp(input logic [AW-1:0] f);
    return {{EXT{f[DW-1]}}, f[DW-1:0]};
  endfunction

  function automatic logic [AW-1:0] step_of(input logic [1:0] s);
    return {{(AW-1){1'b0}}, 1'b1} << s;
  endfunction

  function automatic logic [AW-1:0] jump_join(input logic [AW-1:0] p,
                                              input logic [AW-1:0] f);
    return {p[AW-1:AW-HI], f[JW-1:0]};
  endfunction

  logic [AW-1:0] step;
  logic [AW-1:0] base_up;
  logic [AW-1:0] base_dn;

  assign step    = step_of(size);
  assign base_up = base + step;
  assign base_dn = base - step;

  always_comb begin
    addr        = '0;
    wb_val      = '0;
    wb_sel      = 1'b0;
    is_indirect = 1'b0;
    case (mode)
      M_DISP:    addr = base + sext_disp(imm);
      M_REGIND:  addr = base;
      M_INDEX:   addr = base + index;
      M_ABS:     addr = imm;
      M_MEMIND: begin
        addr        = base;
        is_indirect = 1'b1;
      end
      M_POSTINC: begin
        addr   = base;
        wb_val = base_up;
        wb_sel = 1'b1;
      end
      M_PREDEC: begin
        addr   = base_dn;
        wb_val = base_dn;
        wb_sel = 1'b1;
      end
      M_PCREL:   addr = pc + sext_disp(imm);
      M_PCJMP:   addr = jump_join(pc, imm);
      default:   addr = '0;
    endcase
  end

endmodule

// File: rtl/eau_fsm.sv
module eau_fsm #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] calc_addr,
  input  logic [AW-1:0] calc_wb,
  input  logic          calc_wb_sel,
  input  logic          calc_indirect,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_data,
  output logic [AW-1:0] ea,
  output logic          done,
  output logic          wb_en,
  output logic [AW-1:0] wb_data,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic          busy
);
  import eau_pkg::*;

  state_e state_q;

  logic accept;
  logic fetch_ret;

  assign accept    = start && (state_q == ST_IDLE);
  assign fetch_ret = (state_q == ST_FETCH) && mem_valid;
  assign mem_req   = (state_q == ST_FETCH);
  assign busy      = (state_q == ST_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      done     <= 1'b0;
      wb_en    <= 1'b0;
      ea       <= '0;
      wb_data  <= '0;
      mem_addr <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      if (accept) begin
        if (calc_indirect) begin
          state_q  <= ST_FETCH;
          mem_addr <= calc_addr;
        end else begin
          done    <= 1'b1;
          ea      <= calc_addr;
          wb_en   <= calc_wb_sel;
          wb_data <= calc_wb;
        end
      end else if (fetch_ret) begin
        state_q <= ST_IDLE;
        done    <= 1'b1;
        ea      <= mem_data;
      end
    end
  end

  assert_fetch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

  assert_fetch_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_ret |=> (done && !mem_req && !wb_en && ea == $past(mem_data)));

  assert_wb_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  assert_stray_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !busy && !start) |=> !done);

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !mem_valid) |=> (busy && !done && $stable(mem_addr)));

endmodule

// File: rtl/eff_addr_unit.sv
module eff_addr_unit #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int JW = 26
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] index,
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] imm,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_valid,
  input  logic [AW-1:0] mem_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);
  import eau_pkg::*;

  logic [AW-1:0] calc_addr;
  logic [AW-1:0] calc_wb;
  logic          calc_wb_sel;
  logic          calc_indirect;
  logic          take;

  assign take = start && !busy;

  eau_calc #(.AW(AW), .DW(DW), .JW(JW)) u_calc (
    .mode        (mode),
    .size        (size),
    .base        (base),
    .index       (index),
    .pc          (pc),
    .imm         (imm),
    .addr        (calc_addr),
    .wb_val      (calc_wb),
    .wb_sel      (calc_wb_sel),
    .is_indirect (calc_indirect)
  );

  eau_fsm #(.AW(AW)) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (start),
    .calc_addr     (calc_addr),
    .calc_wb       (calc_wb),
    .calc_wb_sel   (calc_wb_sel),
    .calc_indirect (calc_indirect),
    .mem_valid     (mem_valid),
    .mem_data      (mem_data),
    .ea            (ea),
    .done          (done),
    .wb_en         (wb_en),
    .wb_data       (wb_data),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .busy          (busy)
  );

  assert_postinc_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == M_POSTINC) |=> (done && wb_en && ea == $past(base)));

  assert_predec_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == M_PREDEC) |=> (done && wb_en && ea == wb_data));

  assert_single_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode != M_MEMIND) |=> done);

  assert_indirect_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode == M_MEMIND) |=> (mem_req && !done && mem_addr == $past(base)));

  assert_undef_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (take && mode > M_PCJMP) |=> (done && !wb_en && ea == '0));

endmodule

// File: tb/test_eff_addr_unit.sv
module test_eff_addr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [3:0]  mode;
  logic [1:0]  size;
  logic [31:0] base, index, pc, imm;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_valid;
  logic [31:0] mem_data;
  logic        busy, done, wb_en;
  logic [31:0] ea, wb_data;

  int checks = 0;
  int fails  = 0;

  always #2ns clk = ~clk;

  eff_addr_unit i_eff_addr_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .size(size),
    .base(base), .index(index), .pc(pc), .imm(imm),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
    .mem_data(mem_data), .busy(busy), .done(done), .ea(ea),
    .wb_en(wb_en), .wb_data(wb_data)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sx16(input logic [31:0] v);
    return v[15] ? (32'hFFFF0000 | v[15:0]) : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] exp_ea(input logic [3:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] p,
      input logic [31:0] i);
    logic [31:0] d;
    d = 32'd1 << s;
    case (m)
      4'd0: return b + sx16(i);
      4'd1: return b;
      4'd2: return x + b;
      4'd3: return i;
      4'd5: return b;
      4'd6: return b + ~d + 32'd1;
      4'd7: return sx16(i) + p;
      4'd8: return (p & 32'hFC000000) | (i & 32'h03FFFFFF);
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] m);
    case (m)
      4'd0, 4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R12";
    endcase
  endfunction

  task automatic run_single(input logic [3:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] x, input logic [31:0] p,
      input logic [31:0] i);
    logic [31:0] d;
    bit auto_mod;
    d = 32'd1 << s;
    auto_mod = (m == 4'd5) || (m == 4'd6);
    @(negedge clk);
    mode = m; size = s; base = b; index = x; pc = p; imm = i; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8", "done after start", {31'd0, done}, 32'd1);
    chk(req_of(m), "ea", ea, exp_ea(m, s, b, x, p, i));
    chk("R10", "wb_en", {31'd0, wb_en}, {31'd0, auto_mod});
    if (m == 4'd5) chk("R4", "wb_data", wb_data, b + d);
    if (m == 4'd6) chk("R5", "wb_data", wb_data, b - d);
    chk("R8", "no mem_req", {31'd0, mem_req}, 32'd0);
    @(negedge clk);
    chk("R8", "done one cycle", {31'd0, done}, 32'd0);
  endtask

  task automatic run_ind(input logic [31:0] b, input logic [31:0] data,
                         input int delay, input bit poke);
    @(negedge clk);
    mode = 4'd4; base = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R9", "mem_req", {31'd0, mem_req}, 32'd1);
    chk("R9", "mem_addr", mem_addr, b);
    chk("R9", "no early done", {31'd0, done}, 32'd0);
    for (int k = 0; k < delay; k++) begin
      if (poke && k == 0) begin
        mode = 4'd5; base = ~b; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      chk("R11", "held req", {31'd0, mem_req}, 32'd1);
      chk("R11", "held addr", mem_addr, b);
      chk("R11", "no done while waiting", {31'd0, done}, 32'd0);
    end
    mem_valid = 1'b1; mem_data = data;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R9", "done", {31'd0, done}, 32'd1);
    chk("R9", "ea from memory", ea, data);
    chk("R10", "no wb for indirect", {31'd0, wb_en}, 32'd0);
    chk("R9", "req dropped", {31'd0, mem_req}, 32'd0);
  endtask

  initial begin
    #300000ns;
    fails++;
    $display("FAIL R8 watchdog: actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int seed;
    seed = 32'h5eed1234;
    void'($urandom(seed));
    rst_n = 1'b0; start = 1'b0; mode = 4'd0; size = 2'd0;
    base = '0; index = '0; pc = '0; imm = '0;
    mem_valid = 1'b0; mem_data = '0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'd0, done}, 32'd0);
    chk("R1", "wb_en in reset", {31'd0, wb_en}, 32'd0);
    chk("R1", "mem_req in reset", {31'd0, mem_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", {31'd0, busy}, 32'd0);

    // directed corner cases
    run_single(4'd0, 2'd0, 32'h00001000, 0, 0, 32'h0000FFF0);
    run_single(4'd0, 2'd0, 32'h00001000, 0, 0, 32'hABCD7FFF);
    run_single(4'd1, 2'd0, 32'hDEADBEEF, 0, 0, 0);
    run_single(4'd2, 2'd0, 32'hFFFFFFF0, 32'h20, 0, 0);
    run_single(4'd3, 2'd0, 0, 0, 0, 32'h87654321);
    run_single(4'd5, 2'd3, 32'hFFFFFFFC, 0, 0, 0);
    run_single(4'd6, 2'd0, 32'h00000000, 0, 0, 0);
    run_single(4'd6, 2'd2, 32'h00000100, 0, 0, 0);
    run_single(4'd7, 2'd0, 0, 0, 32'h00400000, 32'h0000FF00);
    run_single(4'd8, 2'd0, 0, 0, 32'hA4001234, 32'hFFFFFFFF);
    run_single(4'd9, 2'd1, 32'h1, 32'h2, 32'h3, 32'h4);
    run_single(4'd15, 2'd1, 32'h1, 32'h2, 32'h3, 32'h4);

    // stray read-valid in idle (R11)
    @(negedge clk);
    mem_valid = 1'b1; mem_data = 32'h12345678;
    @(negedge clk);
    mem_valid = 1'b0;
    chk("R11", "stray valid no done", {31'd0, done}, 32'd0);
    chk("R11", "stray valid no busy", {31'd0, busy}, 32'd0);

    run_ind(32'h00002000, 32'hCAFEF00D, 0, 1'b0);
    run_ind(32'h00003000, 32'h0BADC0DE, 3, 1'b1);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [3:0] m;
      m = 4'($urandom_range(0, 15));
      if (m == 4'd4)
        run_ind($urandom, $urandom, int'($urandom_range(0, 4)), ($urandom & 1) == 1);
      else
        run_single(m, 2'($urandom_range(0, 3)), $urandom, $urandom, $urandom, $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule